// File: doc/BRIEF.md
# Multiply-Accumulate Saturation and Status Unit

This block holds the accumulator bank and the post-multiply logic of a multiply-accumulate engine. There are four accumulators. Each has a 48-bit working range plus 16 guard bits, so 64 bits are stored. A single command port carries an operation code, a target accumulator index, a source index and two 32-bit operands. Every command completes in one clock cycle. One cycle later a valid strobe is raised, together with the new value of the target accumulator.

A mode register selects how the multiplier product is treated. The choices are signed integer, unsigned integer or fractional. In fractional mode the product can be truncated or rounded. A separate mode bit selects whether overflow wraps or clamps. The block checks each product and each saturated accumulator against limits that depend on the mode. It keeps a sticky overflow bit per accumulator and a status group (V, N, Z, EV) that the controlling pipeline reads after every command.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset, every accumulator is 0, the mode is 0, V, N, Z, EV and all per-accumulator overflow bits are 0, and out_valid is 0.
- R2: A command accepted with in_valid=1 raises out_valid for exactly the following cycle, with out_acc holding the target accumulator's value after the command. With no command, out_valid stays 0. Operation codes are: 0 none, 1 load, 2 multiply-accumulate, 3 saturate, 4 flag update, 5 move, 6 mode/status write.
- R3: Load writes the 64-bit value {opnd_b, opnd_a} into the target accumulator.
- R4: Multiply-accumulate in signed-integer mode (FI=0, SU=1) forms the signed 64-bit product and adds it to the target. If the product does not fit in 40 signed bits, V is set. With OMC=0, the sign-extended low 40 bits of the product are added instead. V is sticky and is not cleared by later in-range products.
- R5: With OMC=1, an out-of-range product is replaced by +2^48 if it is positive or -2^48 if it is negative. In unsigned mode an out-of-range product is replaced by +2^48.
- R6: Multiply-accumulate in unsigned mode (FI=0, SU=0) uses zero-extended operands. Any product bit from 40 to 63 sets V. The product is masked to 40 bits before it is added.
- R7: In fractional mode (FI=1) the signed product is shifted arithmetically right by 24 bits. The low 24 bits are a remainder. With RT=1 the result is incremented when the remainder exceeds 0x800000, and on exactly 0x800000 the result's LSB is added. With RT=0 the shifted value is used as it is.
- R8: Saturate in signed or fractional mode checks whether the accumulator fits in 48 signed bits. If it does not, V and that accumulator's overflow bit are set. With OMC=0 the value becomes the sign extension of its low 48 bits.
- R9: With OMC=1, a signed-integer saturate writes 0x000000007FFFFFFF for a positive overflow and 0xFFFFFFFF80000000 for a negative one. A fractional saturate writes 0x00007FFFFFFFFFFF or 0xFFFF800000000000 instead. The sign is taken from bit 63 of the accumulator before saturation.
- R10: Saturate in unsigned mode flags overflow when any of bits 48 to 63 is set. With OMC=1 a value above 2^53 becomes 0 and any other overflowing value becomes 2^48-1. With OMC=0 the value is masked to 48 bits.
- R11: Flag update sets Z when the target accumulator is zero, and otherwise sets N from its bit 47. It sets V equal to the target's overflow bit. It sets EV when bits 63..40 (fractional) or bits 63..32 (signed integer) are not all equal, or when any of bits 63..32 is set (unsigned). Z and N are never both 1.
- R12: Move copies the source accumulator and its overflow bit into the target.
- R13: Mode/status write loads the mode from opnd_a[3:0] (bit 3 RT, bit 2 FI, bit 1 SU, bit 0 OMC). It clears V, N, Z, EV and every per-accumulator overflow bit. Overflow bits change otherwise only by saturate or move, and the mode changes only by this command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command strobe |
| op_sel | input | 3 | Operation code |
| acc_sel | input | 2 | Target accumulator index |
| src_sel | input | 2 | Source accumulator index for move |
| opnd_a | input | 32 | First operand; low word for load; mode for status write |
| opnd_b | input | 32 | Second operand; high word for load |
| out_valid | output | 1 | Result strobe, one cycle after a command |
| out_acc | output | 64 | Target accumulator value after the command |
| mode_o | output | 4 | Current mode {RT, FI, SU, OMC} |
| flag_v | output | 1 | Overflow status |
| flag_n | output | 1 | Negative status |
| flag_z | output | 1 | Zero status |
| flag_ev | output | 1 | Extension-in-use status |
| acc_ovf | output | 4 | Sticky overflow bit per accumulator |

## Verification
Products are tried in range, just inside the 40-bit signed limit (-2^39) and just outside it (+2^39 and 2^60). This separates wrapping from clamping and shows that a later in-range product does not clear V. Fractional remainders are placed below, above and exactly on the half, with both even and odd quotients, and a negative product is used with truncation. Together these tell round-half-even apart from round-half-up and from floor. Saturation is driven with values that fit, values that overflow positively and negatively, and with the unsigned values 2^53 and 2^53+1, which fall on the two sides of the clamp threshold. Flag updates use zero, bit-47-set and extension patterns, each under the three modes.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;

   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_LOAD  = 3'd1,
      OP_MAC   = 3'd2,
      OP_SAT   = 3'd3,
      OP_FLAGS = 3'd4,
      OP_MOVE  = 3'd5,
      OP_CSR   = 3'd6
   } mac_op_e;

   typedef struct packed {
      logic rt;
      logic fi;
      logic su;
      logic omc;
   } mac_mode_t;

endpackage

// File: rtl/mac_prod.sv
// Post-multiply stage: range check, wrap/clamp and fractional rounding.
module mac_prod #(
   parameter int OPND_W     = 32,
   parameter int LIM_W      = 40,
   parameter int FRAC_SH    = 24,
   parameter int FORCE_BIT  = 48,
   parameter bit ROUND_EVEN = 1'b1
) (
   input  logic [OPND_W-1:0]   a,
   input  logic [OPND_W-1:0]   b,
   input  logic                fi,
   input  logic                su,
   input  logic                rt,
   input  logic                omc,
   output logic [2*OPND_W-1:0] prod,
   output logic                ovf
);
   localparam int STORE_W = 2 * OPND_W;
   localparam logic [STORE_W-1:0] ONE      = {{(STORE_W-1){1'b0}}, 1'b1};
   localparam logic [STORE_W-1:0] FORCE_P  = ONE << FORCE_BIT;
   localparam logic [STORE_W-1:0] FORCE_N  = ~FORCE_P + ONE;
   localparam logic [FRAC_SH-1:0] HALF     = {1'b1, {(FRAC_SH-1){1'b0}}};

   logic signed [STORE_W-1:0] sa, sb, sp, sh;
   logic [STORE_W-1:0]        up, s_wrap, u_mask, f_val;
   logic [STORE_W-LIM_W:0]    s_hi;
   logic                      s_fit, u_ovf, rnd_up;
   logic [FRAC_SH-1:0]        rem;

   assign sa     = {{OPND_W{a[OPND_W-1]}}, a};
   assign sb     = {{OPND_W{b[OPND_W-1]}}, b};
   assign sp     = sa * sb;
   assign up     = {{OPND_W{1'b0}}, a} * {{OPND_W{1'b0}}, b};

   assign s_hi   = sp[STORE_W-1:LIM_W-1];
   assign s_fit  = (&s_hi) | ~(|s_hi);
   assign s_wrap = {{(STORE_W-LIM_W){sp[LIM_W-1]}}, sp[LIM_W-1:0]};

   assign u_ovf  = |up[STORE_W-1:LIM_W];
   assign u_mask = {{(STORE_W-LIM_W){1'b0}}, up[LIM_W-1:0]};

   assign sh     = sp >>> FRAC_SH;
   assign rem    = sp[FRAC_SH-1:0];

   generate
      if (ROUND_EVEN) begin : g_half_even
         assign rnd_up = (rem > HALF) || ((rem == HALF) && sh[0]);
      end else begin : g_half_up
         assign rnd_up = (rem >= HALF);
      end
   endgenerate

   assign f_val = sh + {{(STORE_W-1){1'b0}}, rt & rnd_up};

   always_comb begin
      if (fi) begin
         ovf  = 1'b0;
         prod = f_val;
      end else if (su) begin
         ovf  = ~s_fit;
         if (s_fit)    prod = sp;
         else if (omc) prod = sp[STORE_W-1] ? FORCE_N : FORCE_P;
         else          prod = s_wrap;
      end else begin
         ovf  = u_ovf;
         prod = (u_ovf && omc) ? FORCE_P : u_mask;
      end
   end
endmodule

// File: rtl/mac_sat.sv
// Accumulator saturation for the three number formats.
module mac_sat #(
   parameter int STORE_W    = 64,
   parameter int ACC_W      = 48,
   parameter int INT_W      = 32,
   parameter int UCLAMP_BIT = 53
) (
   input  logic [STORE_W-1:0] v,
   input  logic               fi,
   input  logic               su,
   input  logic               omc,
   output logic [STORE_W-1:0] res,
   output logic               ovf
);
   localparam logic [STORE_W-1:0] ONE   = {{(STORE_W-1){1'b0}}, 1'b1};
   localparam logic [STORE_W-1:0] I_POS = (ONE << (INT_W-1)) - ONE;
   localparam logic [STORE_W-1:0] F_POS = (ONE << (ACC_W-1)) - ONE;
   localparam logic [STORE_W-1:0] U_MAX = (ONE << ACC_W) - ONE;
   localparam logic [STORE_W-1:0] U_THR = ONE << UCLAMP_BIT;

   logic [STORE_W-ACC_W:0] s_hi;
   logic                   s_fit, u_ovf;
   logic [STORE_W-1:0]     s_wrap, s_clamp;

   assign s_hi    = v[STORE_W-1:ACC_W-1];
   assign s_fit   = (&s_hi) | ~(|s_hi);
   assign s_wrap  = {{(STORE_W-ACC_W){v[ACC_W-1]}}, v[ACC_W-1:0]};
   assign u_ovf   = |v[STORE_W-1:ACC_W];
   assign s_clamp = fi ? (v[STORE_W-1] ? ~F_POS : F_POS)
                       : (v[STORE_W-1] ? ~I_POS : I_POS);

   always_comb begin
      if (fi || su) begin
         ovf = ~s_fit;
         if (s_fit)    res = v;
         else if (omc) res = s_clamp;
         else          res = s_wrap;
      end else begin
         ovf = u_ovf;
         if (!u_ovf)   res = v;
         else if (omc) res = (v > U_THR) ? '0 : U_MAX;
         else          res = v & U_MAX;
      end
   end
endmodule

// File: rtl/mac_flag_eval.sv
// Status evaluation from one accumulator.
module mac_flag_eval #(
   parameter int STORE_W = 64,
   parameter int ACC_W   = 48,
   parameter int FRAC_EB = 40,
   parameter int INT_EB  = 32
) (
   input  logic [STORE_W-1:0] v,
   input  logic               fi,
   input  logic               su,
   output logic               z,
   output logic               n,
   output logic               ev
);
   logic [STORE_W-FRAC_EB-1:0] f_hi;
   logic [STORE_W-INT_EB-1:0]  i_hi;

   assign f_hi = v[STORE_W-1:FRAC_EB];
   assign i_hi = v[STORE_W-1:INT_EB];
   assign z    = ~(|v);
   assign n    = ~z & v[ACC_W-1];

   always_comb begin
      if (fi)      ev = ~((&f_hi) | ~(|f_hi));
      else if (su) ev = ~((&i_hi) | ~(|i_hi));
      else         ev = |i_hi;
   end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
   import mac_sat_pkg::*;
#(
   parameter int NUM_ACC    = 4,
   parameter int OPND_W     = 32,
   parameter int ACC_W      = 48,
   parameter int LIM_W      = 40,
   parameter int FRAC_SH    = 24,
   parameter int UCLAMP_BIT = 53,
   parameter bit ROUND_EVEN = 1'b1,
   localparam int STORE_W   = 2 * OPND_W,
   localparam int IDX_W     = $clog2(NUM_ACC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [2:0]         op_sel,
   input  logic [IDX_W-1:0]   acc_sel,
   input  logic [IDX_W-1:0]   src_sel,
   input  logic [OPND_W-1:0]  opnd_a,
   input  logic [OPND_W-1:0]  opnd_b,
   output logic               out_valid,
   output logic [STORE_W-1:0] out_acc,
   output logic [3:0]         mode_o,
   output logic               flag_v,
   output logic               flag_n,
   output logic               flag_z,
   output logic               flag_ev,
   output logic [NUM_ACC-1:0] acc_ovf
);
   generate
      if (NUM_ACC < 2 || LIM_W >= ACC_W || ACC_W >= STORE_W ||
          UCLAMP_BIT >= STORE_W || FRAC_SH >= OPND_W) begin : g_bad_cfg
         $error("mac_sat_unit: inconsistent width parameters");
      end
   endgenerate

   mac_op_e            op;
   mac_mode_t          mode_q;
   logic [STORE_W-1:0] acc_all [NUM_ACC];
   logic [STORE_W-1:0] sel_val, src_val, prod, sat_val, next_val;
   logic               prod_ovf, sat_ovf, ev_z, ev_n, ev_ev, wr_en, src_ovf;
   logic               do_csr;

   assign op      = mac_op_e'(op_sel);
   assign sel_val = acc_all[acc_sel];
   assign src_val = acc_all[src_sel];
   assign src_ovf = acc_ovf[src_sel];
   assign do_csr  = in_valid && (op == OP_CSR);

   mac_prod #(
      .OPND_W(OPND_W), .LIM_W(LIM_W), .FRAC_SH(FRAC_SH),
      .FORCE_BIT(ACC_W), .ROUND_EVEN(ROUND_EVEN)
   ) u_prod (
      .a(opnd_a), .b(opnd_b), .fi(mode_q.fi), .su(mode_q.su),
      .rt(mode_q.rt), .omc(mode_q.omc), .prod(prod), .ovf(prod_ovf)
   );

   mac_sat #(
      .STORE_W(STORE_W), .ACC_W(ACC_W), .INT_W(OPND_W), .UCLAMP_BIT(UCLAMP_BIT)
   ) u_sat (
      .v(sel_val), .fi(mode_q.fi), .su(mode_q.su), .omc(mode_q.omc),
      .res(sat_val), .ovf(sat_ovf)
   );

   mac_flag_eval #(
      .STORE_W(STORE_W), .ACC_W(ACC_W), .FRAC_EB(LIM_W), .INT_EB(OPND_W)
   ) u_flag (
      .v(sel_val), .fi(mode_q.fi), .su(mode_q.su),
      .z(ev_z), .n(ev_n), .ev(ev_ev)
   );

   always_comb begin
      wr_en = in_valid;
      unique case (op)
         OP_LOAD: next_val = {opnd_b, opnd_a};
         OP_MAC:  next_val = sel_val + prod;
         OP_SAT:  next_val = sat_val;
         OP_MOVE: next_val = src_val;
         default: begin
            next_val = sel_val;
            wr_en    = 1'b0;
         end
      endcase
   end

   genvar g;
   generate
      for (g = 0; g < NUM_ACC; g++) begin : g_acc
         logic [STORE_W-1:0] q;
         logic               ovf_q;
         logic               hit;

         assign hit        = wr_en && (acc_sel == IDX_W'(g));
         assign acc_all[g] = q;
         assign acc_ovf[g] = ovf_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q     <= '0;
               ovf_q <= 1'b0;
            end else begin
               if (hit) q <= next_val;
               if (do_csr)
                  ovf_q <= 1'b0;
               else if (hit && op == OP_SAT && sat_ovf)
                  ovf_q <= 1'b1;
               else if (hit && op == OP_MOVE)
                  ovf_q <= src_ovf;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         flag_v    <= 1'b0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_ev   <= 1'b0;
         out_valid <= 1'b0;
         out_acc   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_acc <= next_val;
         if (do_csr) begin
            mode_q  <= mac_mode_t'(opnd_a[3:0]);
            flag_v  <= 1'b0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
            flag_ev <= 1'b0;
         end else if (in_valid) begin
            if (op == OP_FLAGS) begin
               flag_v  <= acc_ovf[acc_sel];
               flag_n  <= ev_n;
               flag_z  <= ev_z;
               flag_ev <= ev_ev;
            end else if ((op == OP_MAC && prod_ovf) || (op == OP_SAT && sat_ovf)) begin
               flag_v  <= 1'b1;
            end
         end
      end
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/mac_sat_chk.sv
module mac_sat_chk #(
   parameter int NUM_ACC = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [2:0]         op_sel,
   input logic [3:0]         csr_data,
   input logic               out_valid,
   input logic [3:0]         mode_o,
   input logic               flag_v,
   input logic               flag_n,
   input logic               flag_z,
   input logic               flag_ev,
   input logic [NUM_ACC-1:0] acc_ovf
);
   localparam logic [2:0] C_MOVE = 3'd5;
   localparam logic [2:0] C_CSR  = 3'd6;

   AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2
   AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2
   AST_CSR_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == C_CSR) |=> (!flag_v && !flag_n && !flag_z && !flag_ev
                                          && acc_ovf == '0 && mode_o == $past(csr_data))); // R13
   AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && op_sel == C_CSR) |=> $stable(mode_o)); // R13
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(acc_ovf) & ~acc_ovf)) |-> $past(in_valid && (op_sel == C_CSR || op_sel == C_MOVE))); // R12
   AST_ZN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_z && flag_n)); // R11
endmodule

bind mac_sat_unit mac_sat_chk #(.NUM_ACC(NUM_ACC)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
   .csr_data(opnd_a[3:0]), .out_valid(out_valid), .mode_o(mode_o),
   .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .flag_ev(flag_ev),
   .acc_ovf(acc_ovf)
);

// File: tb/sim_mac_sat_unit.sv
module sim_mac_sat_unit;
   localparam logic [2:0] NOP = 3'd0, LOAD = 3'd1, MAC = 3'd2, SAT = 3'd3,
                          FLG = 3'd4, MOVE = 3'd5, CSR = 3'd6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [1:0]  acc_sel = '0, src_sel = '0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic        out_valid, flag_v, flag_n, flag_z, flag_ev;
   logic [63:0] out_acc;
   logic [3:0]  mode_o, acc_ovf;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mac_sat_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .acc_sel(acc_sel), .src_sel(src_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .out_valid(out_valid), .out_acc(out_acc), .mode_o(mode_o),
      .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .flag_ev(flag_ev),
      .acc_ovf(acc_ovf)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [1:0] idx, input logic [1:0] src,
                        input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      op_sel = op; acc_sel = idx; src_sel = src; opnd_a = a; opnd_b = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 out_valid after command", {63'd0, out_valid}, 64'd1);
   endtask

   task automatic t_reset;
      chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
      chk("R1 mode", {60'd0, mode_o}, 64'd0);
      chk("R1 flags", {60'd0, flag_v, flag_n, flag_z, flag_ev}, 64'd0);
      chk("R1 acc_ovf", {60'd0, acc_ovf}, 64'd0);
      issue(NOP, 2'd3, 2'd0, 32'h0, 32'h0);
      chk("R1 acc3 zero", out_acc, 64'd0);
      @(negedge clk);
      chk("R2 no command no valid", {63'd0, out_valid}, 64'd0);
   endtask

   task automatic t_load;
      issue(LOAD, 2'd1, 2'd0, 32'h12345678, 32'h0000ABCD);
      chk("R3 load", out_acc, 64'h0000ABCD12345678);
   endtask

   task automatic t_smac;
      issue(CSR, 2'd0, 2'd0, 32'h2, 32'h0);
      issue(LOAD, 2'd0, 2'd0, 32'h0, 32'h0);
      issue(MAC, 2'd0, 2'd0, 32'hFFFFFFFD, 32'd7);
      chk("R4 signed mac", out_acc, 64'hFFFFFFFFFFFFFFEB);
      chk("R4 V clear in range", {63'd0, flag_v}, 64'd0);
      issue(MAC, 2'd0, 2'd0, 32'h40000000, 32'h40000000);
      chk("R4 wrapped 2^60 adds 0", out_acc, 64'hFFFFFFFFFFFFFFEB);
      chk("R4 V set", {63'd0, flag_v}, 64'd1);
      issue(MAC, 2'd0, 2'd0, 32'd2, 32'd3);
      chk("R4 in range after ovf", out_acc, 64'hFFFFFFFFFFFFFFF1);
      chk("R4 V sticky", {63'd0, flag_v}, 64'd1);
      issue(MAC, 2'd0, 2'd0, 32'h00100000, 32'h00080000);
      chk("R4 +2^39 wraps", out_acc, 64'hFFFFFF7FFFFFFFF1);
      issue(CSR, 2'd0, 2'd0, 32'h2, 32'h0);
      issue(LOAD, 2'd1, 2'd0, 32'h0, 32'h0);
      issue(MAC, 2'd1, 2'd0, 32'hFFF00000, 32'h00080000);
      chk("R4 -2^39 fits", out_acc, 64'hFFFFFF8000000000);
      chk("R4 -2^39 no V", {63'd0, flag_v}, 64'd0);
   endtask

   task automatic t_omc_prod;
      issue(CSR, 2'd0, 2'd0, 32'h3, 32'h0);
      issue(LOAD, 2'd2, 2'd0, 32'h0, 32'h0);
      issue(MAC, 2'd2, 2'd0, 32'h40000000, 32'h40000000);
      chk("R5 positive forced", out_acc, 64'h0001000000000000);
      chk("R5 V", {63'd0, flag_v}, 64'd1);
      issue(MAC, 2'd2, 2'd0, 32'h80000000, 32'h7FFFFFFF);
      chk("R5 negative forced", out_acc, 64'h0);
      issue(CSR, 2'd0, 2'd0, 32'h1, 32'h0);
      issue(LOAD, 2'd3, 2'd0, 32'h0, 32'h0);
      issue(MAC, 2'd3, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
      chk("R5 unsigned forced", out_acc, 64'h0001000000000000);
   endtask

   task automatic t_umac;
      issue(CSR, 2'd0, 2'd0, 32'h0, 32'h0);
      issue(LOAD, 2'd3, 2'd0, 32'h0, 32'h0);
      issue(MAC, 2'd3, 2'd0, 32'h00010000, 32'h00010000);
      chk("R6 unsigned in range", out_acc, 64'h0000000100000000);
      chk("R6 no V", {63'd0, flag_v}, 64'd0);
      issue(MAC, 2'd3, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
      chk("R6 masked to 40", out_acc, 64'h000000FF00000001);
      chk("R6 V", {63'd0, flag_v}, 64'd1);
   endtask

   task automatic t_frac;
      issue(CSR, 2'd0, 2'd0, 32'hC, 32'h0);
      issue(LOAD, 2'd0, 2'd0, 32'h0, 32'h0);
      issue(MAC, 2'd0, 2'd0, 32'd3, 32'h00C00000);
      chk("R7 below half", out_acc, 64'd2);
      issue(MAC, 2'd0, 2'd0, 32'd1, 32'h01800000);
      chk("R7 half odd rounds up", out_acc, 64'd4);
      issue(MAC, 2'd0, 2'd0, 32'd1, 32'h02800000);
      chk("R7 half even stays", out_acc, 64'd6);
      issue(MAC, 2'd0, 2'd0, 32'd1, 32'h00C00001);
      chk("R7 above half", out_acc, 64'd7);
      issue(CSR, 2'd0, 2'd0, 32'h4, 32'h0);
      issue(MAC, 2'd0, 2'd0, 32'd1, 32'h00C00001);
      chk("R7 truncate", out_acc, 64'd7);
      issue(MAC, 2'd0, 2'd0, 32'hFFFFFFFF, 32'h01800000);
      chk("R7 negative floor", out_acc, 64'd5);
   endtask

   task automatic t_ssat;
      issue(CSR, 2'd0, 2'd0, 32'h2, 32'h0);
      issue(LOAD, 2'd1, 2'd0, 32'h0, 32'h00010000);
      issue(SAT, 2'd1, 2'd0, 32'h0, 32'h0);
      chk("R8 wrap 48", out_acc, 64'h0);
      chk("R8 V and ovf1", {59'd0, flag_v, acc_ovf}, {59'd0, 1'b1, 4'b0010});
      issue(CSR, 2'd0, 2'd0, 32'h4, 32'h0);
      issue(LOAD, 2'd1, 2'd0, 32'h12, 32'h00018000);
      issue(SAT, 2'd1, 2'd0, 32'h0, 32'h0);
      chk("R8 frac wrap sign", out_acc, 64'hFFFF800000000012);
      issue(CSR, 2'd0, 2'd0, 32'h3, 32'h0);
      issue(LOAD, 2'd0, 2'd0, 32'hFFFFFFFF, 32'h00007FFF);
      issue(SAT, 2'd0, 2'd0, 32'h0, 32'h0);
      chk("R8 fits unchanged", out_acc, 64'h00007FFFFFFFFFFF);
      chk("R8 no ovf flag", {60'd0, acc_ovf}, 64'd0);
      issue(LOAD, 2'd1, 2'd0, 32'h0, 32'h00010000);
      issue(SAT, 2'd1, 2'd0, 32'h0, 32'h0);
      chk("R9 int positive clamp", out_acc, 64'h000000007FFFFFFF);
      issue(LOAD, 2'd2, 2'd0, 32'h0, 32'hFFFE0000);
      issue(SAT, 2'd2, 2'd0, 32'h0, 32'h0);
      chk("R9 int negative clamp", out_acc, 64'hFFFFFFFF80000000);
      chk("R9 ovf bits", {60'd0, acc_ovf}, 64'h6);
      issue(CSR, 2'd0, 2'd0, 32'h5, 32'h0);
      issue(LOAD, 2'd1, 2'd0, 32'h0, 32'h00010000);
      issue(SAT, 2'd1, 2'd0, 32'h0, 32'h0);
      chk("R9 frac positive clamp", out_acc, 64'h00007FFFFFFFFFFF);
      issue(LOAD, 2'd2, 2'd0, 32'h0, 32'hFFFE0000);
      issue(SAT, 2'd2, 2'd0, 32'h0, 32'h0);
      chk("R9 frac negative clamp", out_acc, 64'hFFFF800000000000);
   endtask

   task automatic t_usat;
      issue(CSR, 2'd0, 2'd0, 32'h1, 32'h0);
      issue(LOAD, 2'd0, 2'd0, 32'h0, 32'h00200000);
      issue(SAT, 2'd0, 2'd0, 32'h0, 32'h0);
      chk("R10 2^53 to max", out_acc, 64'h0000FFFFFFFFFFFF);
      issue(LOAD, 2'd0, 2'd0, 32'h1, 32'h00200000);
      issue(SAT, 2'd0, 2'd0, 32'h0, 32'h0);
      chk("R10 above 2^53 to zero", out_acc, 64'h0);
      chk("R10 ovf0", {60'd0, acc_ovf}, 64'h1);
      issue(CSR, 2'd0, 2'd0, 32'h0, 32'h0);
      issue(LOAD, 2'd2, 2'd0, 32'h89ABCDEF, 32'h00123456);
      issue(SAT, 2'd2, 2'd0, 32'h0, 32'h0);
      chk("R10 mask 48", out_acc, 64'h0000345689ABCDEF);
      issue(LOAD, 2'd3, 2'd0, 32'h1, 32'h0000FFFF);
      issue(SAT, 2'd3, 2'd0, 32'h0, 32'h0);
      chk("R10 in range", out_acc, 64'h0000FFFF00000001);
      chk("R10 ovf only acc2", {60'd0, acc_ovf}, 64'h4);
   endtask

   task automatic t_flags;
      issue(CSR, 2'd0, 2'd0, 32'h3, 32'h0);
      issue(LOAD, 2'd2, 2'd0, 32'h0, 32'h00010000);
      issue(SAT, 2'd2, 2'd0, 32'h0, 32'h0);
      issue(LOAD, 2'd0, 2'd0, 32'h0, 32'h0);
      issue(FLG, 2'd0, 2'd0, 32'h0, 32'h0);
      chk("R11 zero acc VNZE", {60'd0, flag_v, flag_n, flag_z, flag_ev}, 64'b0010);
      issue(FLG, 2'd2, 2'd0, 32'h0, 32'h0);
      chk("R11 ovf acc VNZE", {60'd0, flag_v, flag_n, flag_z, flag_ev}, 64'b1000);
      issue(CSR, 2'd0, 2'd0, 32'h2, 32'h0);
      issue(LOAD, 2'd0, 2'd0, 32'h0, 32'hFFFFFF80);
      issue(FLG, 2'd0, 2'd0, 32'h0, 32'h0);
      chk("R11 signed int N EV", {60'd0, flag_v, flag_n, flag_z, flag_ev}, 64'b0101);
      issue(CSR, 2'd0, 2'd0, 32'h4, 32'h0);
      issue(FLG, 2'd0, 2'd0, 32'h0, 32'h0);
      chk("R11 frac N no EV", {60'd0, flag_v, flag_n, flag_z, flag_ev}, 64'b0100);
      issue(CSR, 2'd0, 2'd0, 32'h0, 32'h0);
      issue(LOAD, 2'd0, 2'd0, 32'h5, 32'h0);
      issue(FLG, 2'd0, 2'd0, 32'h0, 32'h0);
      chk("R11 unsigned small", {60'd0, flag_v, flag_n, flag_z, flag_ev}, 64'b0000);
      issue(LOAD, 2'd0, 2'd0, 32'h0, 32'h1);
      issue(FLG, 2'd0, 2'd0, 32'h0, 32'h0);
      chk("R11 unsigned EV", {60'd0, flag_v, flag_n, flag_z, flag_ev}, 64'b0001);
   endtask

   task automatic t_move;
      issue(CSR, 2'd0, 2'd0, 32'h3, 32'h0);
      issue(LOAD, 2'd1, 2'd0, 32'h0, 32'h00010000);
      issue(SAT, 2'd1, 2'd0, 32'h0, 32'h0);
      issue(MOVE, 2'd3, 2'd1, 32'h0, 32'h0);
      chk("R12 move value", out_acc, 64'h000000007FFFFFFF);
      chk("R12 move ovf set", {60'd0, acc_ovf}, 64'b1010);
      issue(LOAD, 2'd0, 2'd0, 32'h55, 32'h0);
      issue(MOVE, 2'd1, 2'd0, 32'h0, 32'h0);
      chk("R12 move value 2", out_acc, 64'h55);
      chk("R12 move ovf clear", {60'd0, acc_ovf}, 64'b1000);
   endtask

   task automatic t_csr;
      issue(CSR, 2'd0, 2'd0, 32'hFFFFFFF5, 32'h0);
      chk("R13 mode bits", {60'd0, mode_o}, 64'h5);
      chk("R13 status cleared", {56'd0, flag_v, flag_n, flag_z, flag_ev, acc_ovf}, 64'h0);
      issue(LOAD, 2'd2, 2'd0, 32'h0, 32'h0);
      chk("R13 mode kept", {60'd0, mode_o}, 64'h5);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_load;
      t_smac;
      t_omc_prod;
      t_umac;
      t_frac;
      t_ssat;
      t_usat;
      t_flags;
      t_move;
      t_csr;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule